// File: doc/BRIEF.md
# Word-Indexed Integer Core with Delay Slots

This block is a single-issue 32-bit integer core that runs a fixed set of fourteen instructions. Both of its program counters hold word indices, not byte addresses. One counter names the instruction being executed. The other names the next word to fetch. Every control transfer therefore has exactly one delay-slot instruction. Instructions come from a synchronous, word-addressed read port: data appears one clock after the address is presented. The core keeps its 32 general registers inside and lets the bench or a host read them through a combinational peek port.

A host loads a counter pair and pulses `start`. The core then runs until it meets a system-call instruction or an encoding it does not recognise, and stops there. On stop it raises `halted`. It also raises `error` for the unrecognised case. Both counters are left visible on the ports. Each instruction takes two clocks. Register contents survive across runs and are cleared only by reset.

Top module: `sc_core`

## Requirements
- R1: After reset, `busy`, `halted` and `error` are 0, both counters read 0 and every register peeks as 0.
- R2: A `start` pulse while idle loads `exec_pc`/`fetch_pc` from `init_exec`/`init_fetch`. The word at `init_exec` executes first and the word at `init_fetch` second. After each non-stopping instruction, the executing counter takes the old fetch counter.
- R3: Encoding: opcode in bits 31:26, with rs 25:21, rt 20:16, rd 15:11, shift 10:6, immediate 15:0 and jump index 25:0. The I-type opcodes are addiu 0x09 (sign-extended immediate), andi 0x0c and ori 0x0d (zero-extended), and lui 0x0f (immediate into bits 31:16, low half zero); each writes rt. With opcode 0, the function field in bits 5:0 selects addu 0x21 or xor 0x26, both writing rd.
- R4: Function 0x00 (sll) shifts rt left by the shift field. Function 0x02 (srl) shifts rt right logically. Both write rd.
- R5: beq 0x04 and bne 0x05 set the fetch counter to the delay slot's word index plus the sign-extended immediate, taken on rs==rt and rs!=rt respectively. The delay slot always executes.
- R6: j 0x02 and jal 0x03 set the fetch counter to the delay slot's index bits 31:26 joined with the 26-bit index. jal writes register 31 with four times the word index after the delay slot.
- R7: Function 0x08 (jr) sets the fetch counter to rs shifted right by two.
- R8: Register 0 always reads zero, even after an instruction names it as destination.
- R9: Function 0x0c (syscall) stops the core before its delay slot executes. `halted`=1, `error`=0, `exec_pc` is the stopping word and `fetch_pc` the word after it.
- R10: Any other opcode or function code stops the core the same way with `halted`=1 and `error`=1.
- R11: Additions wrap modulo 2^32 and never stop the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| init_exec | input | 32 | Initial executing word index |
| init_fetch | input | 32 | Initial fetch word index |
| imem_addr | output | 32 | Instruction word address |
| imem_rdata | input | 32 | Instruction word, one clock after address |
| busy | output | 1 | Core is running |
| halted | output | 1 | Last run stopped |
| error | output | 1 | Last stop was an unrecognised encoding |
| exec_pc | output | 32 | Executing-instruction word index |
| fetch_pc | output | 32 | Next-fetch word index |
| peek_sel | input | 5 | Register to observe |
| peek_data | output | 32 | Value of the selected register |

## Verification
A corrupted counter or a wrongly latched instruction word shows up as a wrong stop position. It can also show up as a destination register holding a value from a different instruction. Both are visible at the ports as soon as the run halts, a few dozen clocks later. A decode or extension fault leaves one register off from the model value, and the full peek sweep after every run catches it. A delay slot that is executed or skipped wrongly shifts a counter, or changes a register the program writes only in that slot.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN  = 32;
  localparam int NREGS = 32;
  localparam int RIDX  = $clog2(NREGS);
  localparam int IMMW  = 16;
  localparam int IDXW  = 26;

  localparam logic [5:0] OPC_REG   = 6'h00;
  localparam logic [5:0] OPC_J     = 6'h02;
  localparam logic [5:0] OPC_JAL   = 6'h03;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_BNE   = 6'h05;
  localparam logic [5:0] OPC_ADDIU = 6'h09;
  localparam logic [5:0] OPC_ANDI  = 6'h0c;
  localparam logic [5:0] OPC_ORI   = 6'h0d;
  localparam logic [5:0] OPC_LUI   = 6'h0f;

  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_JR   = 6'h08;
  localparam logic [5:0] FN_SYS  = 6'h0c;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_XOR  = 6'h26;

  localparam logic [RIDX-1:0] LINK_REG = RIDX'(31);

  typedef enum logic [3:0] {
    K_SLL, K_SRL, K_JR, K_SYS, K_ADDU, K_XOR, K_J, K_JAL,
    K_BEQ, K_BNE, K_ADDIU, K_ANDI, K_ORI, K_LUI, K_BAD
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [RIDX-1:0]   rs;
    logic [RIDX-1:0]   rt;
    logic [4:0]        sa;
    logic [IMMW-1:0]   imm;
    logic [IDXW-1:0]   idx;
    logic              wen;
    logic [RIDX-1:0]   wdst;
  } dec_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [XLEN-1:0] word,
  output dec_t            dec
);
  logic [5:0] opc;
  logic [5:0] fn;

  assign opc = word[31:26];
  assign fn  = word[5:0];

  always_comb begin
    dec.rs   = word[25:21];
    dec.rt   = word[20:16];
    dec.sa   = word[10:6];
    dec.imm  = word[15:0];
    dec.idx  = word[25:0];
    dec.kind = K_BAD;
    dec.wen  = 1'b0;
    dec.wdst = word[15:11];
    if (opc == OPC_REG) begin
      case (fn)
        FN_SLL:  begin dec.kind = K_SLL;  dec.wen = 1'b1; end
        FN_SRL:  begin dec.kind = K_SRL;  dec.wen = 1'b1; end
        FN_JR:   dec.kind = K_JR;
        FN_SYS:  dec.kind = K_SYS;
        FN_ADDU: begin dec.kind = K_ADDU; dec.wen = 1'b1; end
        FN_XOR:  begin dec.kind = K_XOR;  dec.wen = 1'b1; end
        default: dec.kind = K_BAD;
      endcase
    end else begin
      dec.wdst = word[20:16];
      case (opc)
        OPC_J:     dec.kind = K_J;
        OPC_JAL:   begin dec.kind = K_JAL; dec.wen = 1'b1; dec.wdst = LINK_REG; end
        OPC_BEQ:   dec.kind = K_BEQ;
        OPC_BNE:   dec.kind = K_BNE;
        OPC_ADDIU: begin dec.kind = K_ADDIU; dec.wen = 1'b1; end
        OPC_ANDI:  begin dec.kind = K_ANDI;  dec.wen = 1'b1; end
        OPC_ORI:   begin dec.kind = K_ORI;   dec.wen = 1'b1; end
        OPC_LUI:   begin dec.kind = K_LUI;   dec.wen = 1'b1; end
        default:   dec.kind = K_BAD;
      endcase
    end
  end
endmodule

// File: rtl/sc_regs.sv
module sc_regs
  import sc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RIDX-1:0] ra_a,
  output logic [XLEN-1:0] rd_a,
  input  logic [RIDX-1:0] ra_b,
  output logic [XLEN-1:0] rd_b,
  input  logic [RIDX-1:0] ra_p,
  output logic [XLEN-1:0] rd_p,
  input  logic            we,
  input  logic [RIDX-1:0] wa,
  input  logic [XLEN-1:0] wd
);
  logic [XLEN-1:0] rf [NREGS];

  for (genvar i = 0; i < NREGS; i++) begin : g_ent
    if (i == 0) begin : g_zero
      assign rf[i] = '0;
    end else begin : g_flop
      logic ce;
      assign ce = we && (wa == RIDX'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rf[i] <= '0;
        else if (ce) rf[i] <= wd;
      end
    end
  end

  assign rd_a = rf[ra_a];
  assign rd_b = rf[ra_b];
  assign rd_p = rf[ra_p];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  kind_e           kind,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [IMMW-1:0] imm,
  input  logic [4:0]      sa,
  input  logic [XLEN-1:0] link,
  output logic [XLEN-1:0] res
);
  logic [XLEN-1:0] sext;
  logic [XLEN-1:0] zext;

  assign sext = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
  assign zext = {{(XLEN-IMMW){1'b0}}, imm};

  always_comb begin
    case (kind)
      K_SLL:   res = b << sa;
      K_SRL:   res = b >> sa;
      K_ADDU:  res = a + b;
      K_XOR:   res = a ^ b;
      K_ADDIU: res = a + sext;
      K_ANDI:  res = a & zext;
      K_ORI:   res = a | zext;
      K_LUI:   res = {imm, {(XLEN-IMMW){1'b0}}};
      K_JAL:   res = link;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/sc_nextpc.sv
module sc_nextpc
  import sc_pkg::*;
(
  input  kind_e           kind,
  input  logic [XLEN-1:0] slot,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  input  logic [IMMW-1:0] imm,
  input  logic [IDXW-1:0] idx,
  output logic [XLEN-1:0] nxt,
  output logic [XLEN-1:0] link
);
  localparam int REGION = XLEN - IDXW;

  logic [XLEN-1:0] seq;
  logic [XLEN-1:0] leap;
  logic [XLEN-1:0] region;
  logic            same;

  assign seq    = slot + XLEN'(1);
  assign leap   = slot + {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
  assign region = {slot[XLEN-1 -: REGION], idx};
  assign same   = (rs_val == rt_val);
  assign link   = seq << 2;

  always_comb begin
    case (kind)
      K_BEQ:       nxt = same  ? leap : seq;
      K_BNE:       nxt = !same ? leap : seq;
      K_J, K_JAL:  nxt = region;
      K_JR:        nxt = rs_val >> 2;
      default:     nxt = seq;
    endcase
  end
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [31:0]     init_exec,
  input  logic [31:0]     init_fetch,
  output logic [31:0]     imem_addr,
  input  logic [31:0]     imem_rdata,
  output logic            busy,
  output logic            halted,
  output logic            error,
  output logic [31:0]     exec_pc,
  output logic [31:0]     fetch_pc,
  input  logic [4:0]      peek_sel,
  output logic [31:0]     peek_data
);
  typedef enum logic [1:0] {ST_IDLE, ST_PRIME, ST_LATCH, ST_EXEC} st_e;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  st_e             st_q, st_d;
  logic [XLEN-1:0] exec_q, exec_d, fetch_q, fetch_d, inst_q, inst_d;
  logic            halt_q, halt_d, err_q, err_d;
  logic            pc_ce, inst_ce, flag_ce, wr_en, stop;

  dec_t            dec;
  logic [XLEN-1:0] rs_val, rt_val, alu_res, nxt_fetch, link;

  sc_decode u_dec (.word(inst_q), .dec(dec));

  sc_regs u_regs (
    .clk(clk), .rst_n(rst_ni),
    .ra_a(dec.rs), .rd_a(rs_val),
    .ra_b(dec.rt), .rd_b(rt_val),
    .ra_p(peek_sel), .rd_p(peek_data),
    .we(wr_en), .wa(dec.wdst), .wd(alu_res)
  );

  sc_nextpc u_npc (
    .kind(dec.kind), .slot(fetch_q), .rs_val(rs_val), .rt_val(rt_val),
    .imm(dec.imm), .idx(dec.idx), .nxt(nxt_fetch), .link(link)
  );

  sc_alu u_alu (
    .kind(dec.kind), .a(rs_val), .b(rt_val), .imm(dec.imm),
    .sa(dec.sa), .link(link), .res(alu_res)
  );

  assign stop = (dec.kind == K_SYS) || (dec.kind == K_BAD);

  always_comb begin
    st_d    = st_q;
    exec_d  = exec_q;
    fetch_d = fetch_q;
    inst_d  = imem_rdata;
    halt_d  = halt_q;
    err_d   = err_q;
    pc_ce   = 1'b0;
    inst_ce = 1'b0;
    flag_ce = 1'b0;
    wr_en   = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        exec_d  = init_exec;
        fetch_d = init_fetch;
        pc_ce   = 1'b1;
        halt_d  = 1'b0;
        err_d   = 1'b0;
        flag_ce = 1'b1;
        st_d    = ST_PRIME;
      end
      ST_PRIME: st_d = ST_LATCH;
      ST_LATCH: begin
        inst_ce = 1'b1;
        st_d    = ST_EXEC;
      end
      ST_EXEC: if (stop) begin
        halt_d  = 1'b1;
        err_d   = (dec.kind == K_BAD);
        flag_ce = 1'b1;
        st_d    = ST_IDLE;
      end else begin
        exec_d  = fetch_q;
        fetch_d = nxt_fetch;
        pc_ce   = 1'b1;
        wr_en   = dec.wen;
        st_d    = ST_LATCH;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      exec_q  <= '0;
      fetch_q <= '0;
      inst_q  <= '0;
      halt_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (pc_ce) begin
        exec_q  <= exec_d;
        fetch_q <= fetch_d;
      end
      if (inst_ce) inst_q <= inst_d;
      if (flag_ce) begin
        halt_q <= halt_d;
        err_q  <= err_d;
      end
    end
  end

  // prime reads the executing word; execute reads the delay slot
  assign imem_addr = (st_q == ST_PRIME) ? exec_q : fetch_q;
  assign busy      = (st_q != ST_IDLE);
  assign halted    = halt_q;
  assign error     = err_q;
  assign exec_pc   = exec_q;
  assign fetch_pc  = fetch_q;

  assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_IDLE && start) |=> (exec_q == $past(init_exec)) && (fetch_q == $past(init_fetch)));

  assert_step_shift_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_EXEC && !stop) |=> (exec_q == $past(fetch_q)));

  assert_lui_low_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_EXEC && dec.kind == K_LUI) |-> (alu_res[15:0] == 16'h0));

  assert_srl_fill_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_EXEC && dec.kind == K_SRL && dec.sa != 5'd0) |-> !alu_res[XLEN-1]);

  assert_stop_freeze_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (halt_q && !start) |=> $stable(exec_q) && $stable(fetch_q) && !busy);

  assert_err_halt_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    err_q |-> halt_q);
endmodule

// File: tb/sim_sc_core.sv
module sim_sc_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] init_exec, init_fetch, imem_addr, imem_rdata;
  logic        busy, halted, error;
  logic [31:0] exec_pc, fetch_pc, peek_data;
  logic [4:0]  peek_sel;

  always #10 clk = ~clk;

  sc_core u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .init_exec(init_exec),
    .init_fetch(init_fetch), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .busy(busy), .halted(halted), .error(error), .exec_pc(exec_pc),
    .fetch_pc(fetch_pc), .peek_sel(peek_sel), .peek_data(peek_data)
  );

  logic [31:0] mem [256];
  always @(posedge clk) imem_rdata <= mem[imem_addr[7:0]];

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] mreg [32];
  logic [31:0] m_exec, m_fetch;
  logic        m_err;

  function automatic logic [31:0] rt_(input int rs, rt, rd, sa, fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], sa[4:0], fn[5:0]};
  endfunction
  function automatic logic [31:0] it_(input int op, rs, rt, imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] jt_(input int op, idx);
    return {op[5:0], idx[25:0]};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_run(input logic [31:0] e0, f0);
    logic [31:0] pe, pf, pd, inst, ninst, a, b, sx, zx;
    bit stp;
    pe = e0; pf = f0; inst = mem[pe[7:0]]; stp = 0; m_err = 0;
    for (int n = 0; n < 4000 && !stp; n++) begin
      ninst = mem[pf[7:0]]; pd = pe; pe = pf; pf = pf + 1;
      a  = mreg[inst[25:21]];
      b  = mreg[inst[20:16]];
      sx = {{16{inst[15]}}, inst[15:0]};
      zx = {16'h0, inst[15:0]};
      if (inst[31:26] == 6'h00) begin
        case (inst[5:0])
          6'h00: mreg[inst[15:11]] = b << inst[10:6];
          6'h02: mreg[inst[15:11]] = b >> inst[10:6];
          6'h08: pf = a >> 2;
          6'h0c: begin stp = 1; pf = pe; pe = pd; end
          6'h21: mreg[inst[15:11]] = a + b;
          6'h26: mreg[inst[15:11]] = a ^ b;
          default: begin stp = 1; m_err = 1; pf = pe; pe = pd; end
        endcase
      end else begin
        case (inst[31:26])
          6'h02: pf = {pe[31:26], inst[25:0]};
          6'h03: begin mreg[31] = pf << 2; pf = {pe[31:26], inst[25:0]}; end
          6'h04: if (a == b) pf = pe + sx;
          6'h05: if (a != b) pf = pe + sx;
          6'h09: mreg[inst[20:16]] = a + sx;
          6'h0c: mreg[inst[20:16]] = a & zx;
          6'h0d: mreg[inst[20:16]] = a | zx;
          6'h0f: mreg[inst[20:16]] = {inst[15:0], 16'h0};
          default: begin stp = 1; m_err = 1; pf = pe; pe = pd; end
        endcase
      end
      mreg[0] = 32'h0;
      inst = ninst;
    end
    m_exec = pe; m_fetch = pf;
  endtask

  task automatic run_prog(input string tag, input logic [31:0] e0, f0);
    int n;
    model_run(e0, f0);
    @(negedge clk);
    init_exec = e0; init_fetch = f0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!halted && n < 20000) begin @(negedge clk); n++; end
    chk(tag, "halted", {31'h0, halted}, 32'h1);
    chk(tag, "busy", {31'h0, busy}, 32'h0);
    chk(tag, "error", {31'h0, error}, {31'h0, m_err});
    chk(tag, "exec_pc", exec_pc, m_exec);
    chk(tag, "fetch_pc", fetch_pc, m_fetch);
    for (int r = 0; r < 32; r++) begin
      peek_sel = r[4:0];
      #1;
      chk(tag, $sformatf("reg %0d", r), peek_data, mreg[r]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected halt");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    for (int i = 0; i < 32; i++) mreg[i] = 32'h0;
    // arithmetic, logic, wrap, r0 and syscall stop
    mem[0]  = it_(6'h0f, 0, 1, 16'h1234);
    mem[1]  = it_(6'h0d, 1, 1, 16'h5678);
    mem[2]  = it_(6'h09, 0, 2, 16'hffff);
    mem[3]  = it_(6'h0c, 2, 3, 16'hf0f0);
    mem[4]  = rt_(1, 2, 4, 0, 6'h21);
    mem[5]  = rt_(1, 3, 5, 0, 6'h26);
    mem[6]  = it_(6'h0f, 0, 6, 16'h7fff);
    mem[7]  = it_(6'h0d, 6, 6, 16'hffff);
    mem[8]  = it_(6'h09, 6, 7, 16'h0001);
    mem[9]  = rt_(2, 2, 8, 0, 6'h21);
    mem[10] = it_(6'h09, 1, 0, 16'h0005);
    mem[11] = rt_(0, 1, 9, 0, 6'h21);
    mem[12] = rt_(0, 1, 10, 4, 6'h00);
    mem[13] = rt_(0, 2, 11, 31, 6'h02);
    mem[14] = rt_(0, 0, 0, 0, 6'h0c);
    mem[15] = it_(6'h09, 0, 12, 16'd99);
    // shift sweep: every amount 2..31, alternating direction
    mem[32] = it_(6'h0f, 0, 1, 16'h9669);
    mem[33] = it_(6'h0d, 1, 1, 16'ha5c3);
    for (int k = 2; k < 32; k++)
      mem[32+k] = rt_(0, 1, k, k, (k % 2) ? 6'h02 : 6'h00);
    mem[64] = rt_(0, 0, 0, 0, 6'h0c);
    mem[65] = it_(6'h09, 0, 2, 16'd1);
    // branches with delay slots
    mem[80] = it_(6'h09, 0, 1, 16'd5);
    mem[81] = it_(6'h09, 0, 2, 16'd0);
    mem[82] = rt_(2, 1, 2, 0, 6'h21);
    mem[83] = it_(6'h09, 1, 1, 16'hffff);
    mem[84] = it_(6'h05, 1, 0, 16'hfffd);
    mem[85] = it_(6'h09, 3, 3, 16'd1);
    mem[86] = it_(6'h04, 1, 0, 16'd2);
    mem[87] = it_(6'h09, 0, 4, 16'd7);
    mem[88] = it_(6'h09, 0, 5, 16'd9);
    mem[89] = it_(6'h04, 1, 2, 16'd5);
    mem[90] = it_(6'h09, 0, 6, 16'd3);
    mem[91] = rt_(0, 0, 0, 0, 6'h0c);
    mem[92] = it_(6'h09, 0, 6, 16'd4);
    // call and return
    mem[100] = jt_(6'h03, 120);
    mem[101] = it_(6'h09, 0, 7, 16'd11);
    mem[102] = it_(6'h09, 0, 8, 16'd12);
    mem[103] = jt_(6'h02, 110);
    mem[104] = it_(6'h09, 0, 9, 16'd13);
    mem[105] = it_(6'h09, 0, 10, 16'd14);
    mem[110] = rt_(0, 0, 0, 0, 6'h0c);
    mem[120] = it_(6'h09, 31, 14, 16'd0);
    mem[121] = rt_(31, 0, 0, 0, 6'h08);
    mem[122] = it_(6'h09, 0, 15, 16'd22);
    // unrecognised opcode and function
    mem[130] = it_(6'h09, 0, 16, 16'd1);
    mem[131] = {6'h3f, 26'h0};
    mem[132] = it_(6'h09, 0, 17, 16'd2);
    mem[140] = it_(6'h09, 0, 18, 16'd3);
    mem[141] = rt_(0, 0, 0, 0, 6'h01);
    mem[142] = it_(6'h09, 0, 19, 16'd4);
    // non-adjacent starting pair
    mem[150] = it_(6'h09, 0, 20, 16'h55);
    mem[160] = it_(6'h09, 20, 21, 16'd1);
    mem[161] = rt_(0, 0, 0, 0, 6'h0c);

    start = 1'b0; init_exec = '0; init_fetch = '0; peek_sel = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1", "busy", {31'h0, busy}, 32'h0);
    chk("R1", "halted", {31'h0, halted}, 32'h0);
    chk("R1", "error", {31'h0, error}, 32'h0);
    chk("R1", "exec_pc", exec_pc, 32'h0);
    chk("R1", "fetch_pc", fetch_pc, 32'h0);
    for (int r = 0; r < 32; r += 5) begin
      peek_sel = r[4:0];
      #1;
      chk("R1", $sformatf("reg %0d", r), peek_data, 32'h0);
    end

    run_prog("R3 R8 R9 R11", 32'd0, 32'd1);
    chk("R11", "wrap add", mreg[7], 32'h8000_0000);
    chk("R9", "delay slot skipped", mreg[12], 32'h0);
    run_prog("R4", 32'd32, 32'd33);
    run_prog("R5", 32'd80, 32'd81);
    run_prog("R6 R7", 32'd100, 32'd101);
    chk("R6", "link value", mreg[14], 32'd408);
    run_prog("R10 op", 32'd130, 32'd131);
    run_prog("R10 fn", 32'd140, 32'd141);
    run_prog("R2", 32'd150, 32'd160);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule